// File: doc/BRIEF.md
# Double-to-Single Narrowing Converter with Round-to-Odd

This block narrows an IEEE-754 binary64 operand to binary32. It always rounds by truncating toward zero and then forcing the result's least significant bit to one whenever any magnitude was discarded. This is round-to-odd, also called von Neumann rounding. It has no rounding-mode input, so it neither consults nor changes any rounding mode configured elsewhere in the datapath. A later rounding of the narrowed value to fewer bits therefore cannot suffer from double rounding.

Each accepted operand produces one registered result one clock later. An incoming sticky exception-flag vector is combined with the flags raised by the conversion and returned beside the result, so the caller can write it straight back to its status state. A flush-to-zero control flushes subnormal operands and subnormal-range results to signed zero.

Top module: `f64_to_f32_rto`

## Requirements
- R1: When `valid_i` is high at a rising clock edge, `valid_o` is high in the following cycle with `result_o` and `flags_o` for that operand. After any edge where `valid_i` was low, `valid_o` is low.
- R2: While `rst_ni` is low, `valid_o`, `result_o` and `flags_o` are all zero.
- R3: A finite operand whose truncated magnitude lies in the binary32 normal range gives the sign, the rebiased exponent and the top 23 fraction bits. If any of the lower 29 fraction bits is set, result bit 0 is forced to 1 and inexact is raised.
- R4: A normal-range conversion that discards no set bit is exact and raises no flag.
- R5: A finite operand of magnitude at or above 2^128 gives the sign with exponent field 0xFE and all fraction bits set. It raises overflow and inexact and never produces infinity.
- R6: With `ftz_i` low, a nonzero finite operand below 2^-126 gives a subnormal binary32: exponent field 0 and the magnitude truncated to a multiple of 2^-149, with bit 0 forced to 1 when inexact. Underflow and inexact are raised only when it is inexact. A binary64 subnormal operand therefore yields magnitude code 0x00000001.
- R7: With `ftz_i` high, a binary64 subnormal operand gives signed zero and raises no flag. A normal operand whose result would be subnormal gives signed zero and raises underflow only.
- R8: A NaN operand gives exponent field 0xFF and keeps its sign. It sets result bit 22 (quiet) and copies operand fraction bits 50..29 into result bits 21..0. Invalid is raised only for a signalling NaN, which is one with operand bit 51 equal to 0.
- R9: Infinities and zeros convert exactly, keeping their sign, and raise no flag.
- R10: `flags_o` equals `flags_i` ORed with the raised flags. The bit positions are [0] invalid, [1] overflow, [2] underflow and [3] inexact. No incoming flag is ever cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand strobe |
| din_i | input | 64 | binary64 operand |
| ftz_i | input | 1 | Flush-to-zero enable |
| flags_i | input | 4 | Incoming sticky flags |
| valid_o | output | 1 | Result strobe |
| result_o | output | 32 | binary32 result |
| flags_o | output | 4 | Updated sticky flags |

## Verification
The assertions rely on `valid_i`, `ftz_i`, `flags_i` and `din_i` being held at known values from reset onward, and on `valid_i` being low during reset. Only under those conditions does comparing each output with the inputs of the previous edge hold. The bench drives every input from negative-edge tasks, keeps `valid_i` low while reset is applied, and always presents defined operand bits, including on idle cycles. Stimulus mixes directed corner operands with random ones concentrated at the overflow threshold, the subnormal boundary, both special exponents and exactly representable fractions.

// File: rtl/f64_to_f32_rto_pkg.sv
package f64_to_f32_rto_pkg;
  localparam int DE_IN    = 11;
  localparam int DF_IN    = 52;
  localparam int DW_IN    = 1 + DE_IN + DF_IN;
  localparam int DE_OUT   = 8;
  localparam int DF_OUT   = 23;
  localparam int DW_OUT   = 1 + DE_OUT + DF_OUT;
  localparam int BIAS_IN  = (1 << (DE_IN - 1)) - 1;
  localparam int BIAS_OUT = (1 << (DE_OUT - 1)) - 1;

  localparam int FLAG_W = 4;
  localparam int FL_INV = 0;
  localparam int FL_OVF = 1;
  localparam int FL_UNF = 2;
  localparam int FL_INX = 3;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_SUB,
    CLS_NORM,
    CLS_INF,
    CLS_NAN
  } cls_e;

  typedef struct packed {
    logic             sign;
    logic [DE_IN-1:0] exp;
    logic [DF_IN-1:0] frac;
  } dbl_t;
endpackage

// File: rtl/f64_to_f32_rto_unpack.sv
module f64_to_f32_rto_unpack
  import f64_to_f32_rto_pkg::*;
(
  input  logic [DW_IN-1:0] din_i,
  input  logic             ftz_i,
  output dbl_t             fld_o,
  output cls_e             cls_o,
  output logic             snan_o
);
  logic exp_max, exp_zero, frac_zero;

  assign fld_o     = dbl_t'(din_i);
  assign exp_max   = &fld_o.exp;
  assign exp_zero  = ~|fld_o.exp;
  assign frac_zero = ~|fld_o.frac;

  always_comb begin
    if (exp_max)       cls_o = frac_zero ? CLS_INF : CLS_NAN;
    else if (exp_zero) cls_o = (frac_zero || ftz_i) ? CLS_ZERO : CLS_SUB;
    else               cls_o = CLS_NORM;
  end

  // quiet bit clear on a NaN marks it signalling
  assign snan_o = exp_max & ~frac_zero & ~fld_o.frac[DF_IN-1];
endmodule

// File: rtl/f64_to_f32_rto_narrow.sv
module f64_to_f32_rto_narrow
  import f64_to_f32_rto_pkg::*;
(
  input  logic              sign_i,
  input  logic [DE_IN-1:0]  exp_i,
  input  logic [DF_IN-1:0]  frac_i,
  input  cls_e              cls_i,
  input  logic              snan_i,
  input  logic              ftz_i,
  output logic [DW_OUT-1:0] res_o,
  output logic [FLAG_W-1:0] raised_o
);
  localparam int TRUNC_W   = DF_IN - DF_OUT;
  localparam int EXP_OFS   = BIAS_IN - BIAS_OUT;
  localparam int SUB_SHIFT = EXP_OFS + TRUNC_W + 1;
  localparam int OVF_EXP   = EXP_OFS + (1 << DE_OUT) - 1;
  localparam int SH_W      = 6;
  localparam int SH_MAX    = (1 << SH_W) - 1;
  localparam int SIG_W     = DF_IN + 1;
  localparam int WIDE_W    = SIG_W + SH_MAX + 1;

  localparam logic [DE_IN-1:0] EXP_OFS_V   = DE_IN'(EXP_OFS);
  localparam logic [DE_IN-1:0] OVF_EXP_V   = DE_IN'(OVF_EXP);
  localparam logic [DE_IN:0]   SUB_SHIFT_V = (DE_IN+1)'(SUB_SHIFT);
  localparam logic [DE_IN:0]   SH_MAX_V    = (DE_IN+1)'(SH_MAX);

  logic [SIG_W-1:0]  sig;
  logic [DE_IN-1:0]  e_eff;
  logic [DE_IN:0]    sh_full;
  logic [SH_W-1:0]   sh;
  logic [WIDE_W-1:0] wide;
  logic [DF_OUT-1:0] sub_frac;
  logic              sub_lost, trunc_lost;
  logic [DE_OUT-1:0] eb;

  // binary64 subnormals sit far below the smallest target step: model them with exponent 1
  assign sig     = (cls_i == CLS_NORM) ? {1'b1, frac_i} : {1'b0, frac_i};
  assign e_eff   = (cls_i == CLS_NORM) ? exp_i : DE_IN'(1);
  assign sh_full = SUB_SHIFT_V - {1'b0, e_eff};
  // any shift beyond SH_MAX already empties the significand
  assign sh       = (sh_full > SH_MAX_V) ? SH_W'(SH_MAX) : sh_full[SH_W-1:0];
  assign wide     = {sig, {(SH_MAX+1){1'b0}}} >> sh;
  assign sub_frac = wide[SH_MAX+1 +: DF_OUT];
  assign sub_lost = |wide[SH_MAX:0];

  assign trunc_lost = |frac_i[TRUNC_W-1:0];
  assign eb         = DE_OUT'(exp_i - EXP_OFS_V);

  always_comb begin
    res_o    = '0;
    raised_o = '0;
    case (cls_i)
      CLS_ZERO: res_o = {sign_i, {(DW_OUT-1){1'b0}}};
      CLS_INF:  res_o = {sign_i, {DE_OUT{1'b1}}, {DF_OUT{1'b0}}};
      CLS_NAN: begin
        res_o = {sign_i, {DE_OUT{1'b1}}, 1'b1, frac_i[DF_IN-2 -: DF_OUT-1]};
        raised_o[FL_INV] = snan_i;
      end
      default: begin
        if (cls_i == CLS_NORM && exp_i >= OVF_EXP_V) begin
          res_o = {sign_i, {(DE_OUT-1){1'b1}}, 1'b0, {DF_OUT{1'b1}}};
          raised_o[FL_OVF] = 1'b1;
          raised_o[FL_INX] = 1'b1;
        end else if (cls_i == CLS_NORM && exp_i > EXP_OFS_V) begin
          res_o = {sign_i, eb, frac_i[DF_IN-1 -: DF_OUT-1],
                   frac_i[TRUNC_W] | trunc_lost};
          raised_o[FL_INX] = trunc_lost;
        end else if (ftz_i) begin
          res_o = {sign_i, {(DW_OUT-1){1'b0}}};
          raised_o[FL_UNF] = 1'b1;
        end else begin
          res_o = {sign_i, {DE_OUT{1'b0}}, sub_frac[DF_OUT-1:1],
                   sub_frac[0] | sub_lost};
          raised_o[FL_UNF] = sub_lost;
          raised_o[FL_INX] = sub_lost;
        end
      end
    endcase
  end
endmodule

// File: rtl/f64_to_f32_rto.sv
module f64_to_f32_rto
  import f64_to_f32_rto_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DW_IN-1:0]  din_i,
  input  logic              ftz_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic [DW_OUT-1:0] result_o,
  output logic [FLAG_W-1:0] flags_o
);
  dbl_t              fld;
  cls_e              cls;
  logic              snan;
  logic [DW_OUT-1:0] core_res;
  logic [FLAG_W-1:0] core_raised;

  f64_to_f32_rto_unpack u_unpack (
    .din_i  (din_i),
    .ftz_i  (ftz_i),
    .fld_o  (fld),
    .cls_o  (cls),
    .snan_o (snan)
  );

  f64_to_f32_rto_narrow u_narrow (
    .sign_i   (fld.sign),
    .exp_i    (fld.exp),
    .frac_i   (fld.frac),
    .cls_i    (cls),
    .snan_i   (snan),
    .ftz_i    (ftz_i),
    .res_o    (core_res),
    .raised_o (core_raised)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= core_res;
        flags_o  <= flags_i | core_raised;
      end
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R10
  sticky_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((flags_o & $past(flags_i)) == $past(flags_i)));

  // R8
  nan_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (&result_o[30:23]) && (|result_o[22:0])) |-> result_o[22]);

  // R7
  ftz_no_subnormal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(ftz_i)) |-> !((result_o[30:23] == '0) && (|result_o[22:0])));

  // R5
  no_overflow_to_inf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (&result_o[30:23])) |-> (&$past(din_i[62:52])));
endmodule

// File: tb/f64_to_f32_rto_bench.sv
module f64_to_f32_rto_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [63:0] din_i = '0;
  logic        ftz_i = 1'b0;
  logic [3:0]  flags_i = '0;
  logic        valid_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  typedef struct {
    logic [31:0] r;
    logic [3:0]  f;
    string       tag;
  } exp_t;
  exp_t pend[$];

  always #5 clk = ~clk;

  f64_to_f32_rto u_f64_to_f32_rto (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .din_i(din_i),
    .ftz_i(ftz_i), .flags_i(flags_i), .valid_o(valid_o),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // behavioural reference: normalise by locating the leading one, then truncate
  function automatic void ref_conv(input logic [63:0] x, input logic ftz,
                                   output logic [31:0] r, output logic [3:0] fl,
                                   output string tag);
    logic s = x[63];
    int ex = int'(x[62:52]);
    logic [63:0] sig, kept;
    int e2, p, top, sh;
    logic lost;
    fl = 4'b0;
    if (ex == 2047) begin
      if (x[51:0] == 0) begin r = {s, 8'hFF, 23'h0}; tag = "R9"; end
      else begin r = {s, 8'hFF, 1'b1, x[50:29]}; fl[0] = ~x[51]; tag = "R8"; end
    end else if (x[62:0] == 0) begin
      r = {s, 31'h0}; tag = "R9";
    end else if (ex == 0 && ftz) begin
      r = {s, 31'h0}; tag = "R7";
    end else begin
      if (ex == 0) begin sig = {12'h0, x[51:0]}; e2 = -1074; end
      else begin sig = {11'h0, 1'b1, x[51:0]}; e2 = ex - 1075; end
      p = 0;
      for (int i = 0; i < 64; i++) if (sig[i]) p = i;
      top = e2 + p;
      if (top > 127) begin
        r = {s, 8'hFE, 23'h7FFFFF}; fl = 4'b1010; tag = "R5";
      end else if (top >= -126) begin
        kept = sig >> (p - 23);
        lost = (sig & ((64'd1 << (p - 23)) - 64'd1)) != 0;
        r = {s, 8'(top + 127), kept[22:1], kept[0] | lost};
        fl[3] = lost;
        tag = lost ? "R3" : "R4";
      end else begin
        sh = -149 - e2;
        if (sh >= 64) begin kept = 0; lost = 1'b1; end
        else begin
          kept = sig >> sh;
          lost = (sig & ((64'd1 << sh) - 64'd1)) != 0;
        end
        if (ftz) begin
          r = {s, 31'h0}; fl = 4'b0100; tag = "R7";
        end else begin
          r = {s, 8'h00, kept[22:1], kept[0] | lost};
          fl = lost ? 4'b1100 : 4'b0000;
          tag = "R6";
        end
      end
    end
  endfunction

  task automatic step(input bit v, input logic [63:0] d, input logic ftz,
                      input logic [3:0] fi);
    exp_t e;
    logic [31:0] rr;
    logic [3:0] ff;
    string tg;
    @(negedge clk);
    if (pend.size() > 0) begin
      e = pend.pop_front();
      chk(valid_o === 1'b1, "R1", "valid_o", {63'h0, valid_o}, 64'h1);
      chk(result_o === e.r, e.tag, "result", {32'h0, result_o}, {32'h0, e.r});
      chk(flags_o === e.f, {e.tag, "/R10"}, "flags", {60'h0, flags_o}, {60'h0, e.f});
    end else begin
      chk(valid_o === 1'b0, "R1", "idle valid_o", {63'h0, valid_o}, 64'h0);
    end
    valid_i = v; din_i = d; ftz_i = ftz; flags_i = fi;
    if (v) begin
      ref_conv(d, ftz, rr, ff, tg);
      e.r = rr; e.f = ff | fi; e.tag = tg;
      pend.push_back(e);
    end
  endtask

  function automatic logic [63:0] rand_op();
    logic [63:0] x = {$urandom, $urandom};
    int m = $urandom % 8;
    case (m)
      0: x[62:52] = 11'(866 + ($urandom % 60));
      1: x[62:52] = 11'(1148 + ($urandom % 6));
      2: x[62:52] = 11'h000;
      3: x[62:52] = 11'h7FF;
      4: ;
      5: begin x[62:52] = 11'(897 + ($urandom % 254)); x[28:0] = '0; end
      default: x[62:52] = 11'(897 + ($urandom % 254));
    endcase
    return x;
  endfunction

  initial begin
    #(10 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(valid_o === 1'b0, "R2", "reset valid_o", {63'h0, valid_o}, 64'h0);
    chk(result_o === 32'h0, "R2", "reset result_o", {32'h0, result_o}, 64'h0);
    chk(flags_o === 4'h0, "R2", "reset flags_o", {60'h0, flags_o}, 64'h0);
    rst_ni = 1'b1;

    step(1, 64'h3FF0000000000000, 0, 4'h0);  // R4 1.0
    step(1, 64'h3FF0000000000001, 0, 4'h0);  // R3 lsb forced
    step(1, 64'hBFF8000000000000, 0, 4'h0);  // R4 -1.5
    step(1, 64'h47EFFFFFE0000000, 0, 4'h0);  // R4 max finite
    step(1, 64'h47F0000000000000, 0, 4'h0);  // R5 2^128
    step(1, 64'hC7EFFFFFF0000000, 0, 4'h0);  // R3 just above max, truncated
    step(0, 64'h0, 0, 4'h0);
    step(1, 64'hFFEFFFFFFFFFFFFF, 0, 4'h0);  // R5 largest double negative
    step(1, 64'h7FF0000000000000, 0, 4'h0);  // R9 +inf
    step(1, 64'h8000000000000000, 0, 4'h0);  // R9 -0
    step(1, 64'h7FF0000000000001, 0, 4'h0);  // R8 sNaN
    step(1, 64'h7FF4000020000000, 0, 4'h0);  // R8 payload carry
    step(1, 64'hFFF8000000000000, 0, 4'h0);  // R8 qNaN no flag
    step(1, 64'h36A0000000000000, 0, 4'h0);  // R6 2^-149 exact
    step(1, 64'h3690000000000000, 0, 4'h0);  // R6 2^-150 total loss
    step(1, 64'h380FFFFFFFFFFFFF, 0, 4'h0);  // R6 just under min normal
    step(1, 64'h0000000000000001, 0, 4'h0);  // R6 double subnormal
    step(1, 64'h8000000000000001, 1, 4'h0);  // R7 subnormal input flushed
    step(1, 64'h3800000000000000, 1, 4'h0);  // R7 result flushed
    step(1, 64'h3810000000000000, 1, 4'h0);  // R4 min normal under ftz
    step(1, 64'h3FF0000000000000, 0, 4'h5);  // R10 keep incoming
    step(1, 64'h7FF0000000000001, 0, 4'hA);  // R10 merge
    step(0, 64'h0, 0, 4'hF);
    step(0, 64'h0, 0, 4'h0);

    for (int i = 0; i < 4000; i++)
      step(($urandom % 4) != 0, rand_op(), ($urandom % 4) == 0, 4'($urandom));
    step(0, 64'h0, 0, 4'h0);
    step(0, 64'h0, 0, 4'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule